// File: doc/BRIEF.md
# Programmable-Frame Synchronous Serial Transmitter

This block serialises parallel words onto a single data line and advances one bit for each pulse of a bit-clock enable. Each frame starts on an event from one of several start sources, which configuration selects. The line then stays idle for a programmed number of bit periods. An optional synchronisation field follows, and then a programmed number of data words of programmed length goes out. Bit order is selectable, and the line rests at a programmable level between frames.

Data words enter on a valid/ready stream. `s_ready` goes high for a single clock. That clock must be a bit-enable cycle in which the sequencer needs a new word. `s_ready` never depends on `s_valid`. A word is consumed only when both are high in the same clock. If `s_valid` is low at that moment, the producer has missed the slot. The transmitter does not wait: it sends that slot at the idle level and flags an underrun. Configuration inputs must be held stable while `tx_busy` is high.

Lengths and counts use a minus-one encoding. A field value of 0 means one bit or one word.

Top module: `frame_serial_tx`

## Requirements
- R1: After reset, and whenever `tx_busy` is low, `tx_data` equals `cfg_idle_lvl`. `tx_busy`, `s_ready` and `underrun` are low after reset.
- R2: A frame starts only on a clock where `bit_en` is high and `start_evt[cfg_start_sel]` is high while idle. Activity on unselected sources has no effect.
- R3: With `cfg_dly` = N, the line shows the idle level for N bit periods after the start edge, and the first frame bit appears on the edge after that. With N = 0, the first bit appears on the start edge itself.
- R4: When `cfg_sync_en` is 1, the frame opens with `cfg_sync_len_m1`+1 bits of `cfg_sync_data`. When it is 0, no sync bits are sent.
- R5: Each data word occupies `cfg_word_len_m1`+1 bit periods, and only its low `cfg_word_len_m1`+1 bits are sent.
- R6: Each start produces exactly `cfg_word_cnt_m1`+1 word slots. After the last bit of the last slot, the next bit enable returns the line to idle.
- R7: With `cfg_msb_first` = 1, the highest sent bit of a field goes first. With 0, bit 0 goes first. The same order applies to the sync field.
- R8: `s_ready` is high only in a `bit_en` clock at a word boundary. A word is taken when `s_valid` and `s_ready` are both high.
- R9: If `s_valid` is low while `s_ready` is high, `underrun` pulses for one clock on the next clock. The slot is sent at the idle level and still counts toward the word count.
- R10: Start events that arrive while a frame is in progress, including on the edge of its final bit, are ignored.
- R11: `tx_busy` rises on the start edge and falls on the edge that returns the line to idle.
- R12: Between bit enables, `tx_data` and `tx_busy` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one bit period per pulse |
| start_evt | input | NSRC | Candidate start event sources |
| cfg_start_sel | input | clog2(NSRC) | Index of the active start source |
| cfg_dly | input | DLY_W | Bit periods between start and first bit |
| cfg_sync_en | input | 1 | Send the sync field |
| cfg_sync_len_m1 | input | clog2(SYNC_W) | Sync length minus one |
| cfg_sync_data | input | SYNC_W | Sync field value |
| cfg_word_len_m1 | input | clog2(WORD_W) | Word length minus one |
| cfg_word_cnt_m1 | input | CNT_W | Words per start minus one |
| cfg_msb_first | input | 1 | 1: highest bit first, 0: bit 0 first |
| cfg_idle_lvl | input | 1 | Line level outside transmitted bits |
| s_valid | input | 1 | Word stream valid |
| s_data | input | WORD_W | Word stream data |
| s_ready | output | 1 | Word stream ready |
| tx_data | output | 1 | Serial data line |
| tx_busy | output | 1 | Frame in progress |
| underrun | output | 1 | One-clock pulse for a slot left without data |

## Verification
The assertions check the cycle-level rules on every clock. These are: the idle level whenever no frame is active, `s_ready` being confined to bit-enable clocks, the underrun pulse following exactly the missed handshakes, a frame never starting without a selected event, and the busy state holding between enables. The content of a frame can only be shown by the bench's scenarios comparing each bit period against a model. That content covers the delay length, sync presence and order, word length, slot count, and the idle bits in underrun slots. The bench's scenarios also show that starts arriving mid-frame or on unselected sources are ignored.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SYNC = 2'd2,
    ST_DATA = 2'd3
  } txst_e;
endpackage

// File: rtl/ssx_start_pick.sv
module ssx_start_pick #(
  parameter int NSRC = 4,
  localparam int SSW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] start_evt,
  input  logic [SSW-1:0]  sel,
  output logic            hit
);
  logic [NSRC-1:0] match;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign match[g] = start_evt[g] && (sel == SSW'(g));
  end

  assign hit = |match;
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int SHW = 16,
  localparam int LW = $clog2(SHW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [SHW-1:0] load_val,
  input  logic [LW-1:0]  load_len_m1,
  input  logic           msb_first,
  output logic           bit_o
);
  logic [SHW-1:0] sh_q;
  logic [SHW-1:0] norm;

  // Place the field so that bit 0 of the register is always the next bit out.
  always_comb begin
    norm = '0;
    for (int i = 0; i < SHW; i++) begin
      if (!msb_first) begin
        norm[i] = load_val[i];
      end else if (LW'(i) <= load_len_m1) begin
        norm[i] = load_val[load_len_m1 - LW'(i)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= norm;
    end else if (shift) begin
      sh_q <= {1'b0, sh_q[SHW-1:1]};
    end
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/ssx_sequencer.sv
module ssx_sequencer
  import ssx_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int CNT_W = 4,
  parameter int LW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start_hit,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic             cfg_sync_en,
  input  logic [LW-1:0]    sync_len_m1,
  input  logic [LW-1:0]    word_len_m1,
  input  logic [CNT_W-1:0] word_cnt_m1,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             ld_sync,
  output logic             ld_word,
  output logic             shift,
  output logic             line_on,
  output logic             busy,
  output logic             underrun
);
  txst_e            st_q, st_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [LW-1:0]    bit_q, bit_d;
  logic [CNT_W-1:0] word_q, word_d;
  logic             on_q, on_d;
  logic             und_q;
  logic             frame_go;
  logic             word_go;
  logic             first_word;

  always_comb begin
    st_d       = st_q;
    dly_d      = dly_q;
    bit_d      = bit_q;
    word_d     = word_q;
    on_d       = on_q;
    frame_go   = 1'b0;
    word_go    = 1'b0;
    first_word = 1'b0;
    ld_sync    = 1'b0;
    ld_word    = 1'b0;
    shift      = 1'b0;

    if (bit_en) begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_hit) begin
            if (cfg_dly == '0) begin
              frame_go = 1'b1;
            end else begin
              st_d  = ST_WAIT;
              dly_d = cfg_dly;
            end
          end
        end
        ST_WAIT: begin
          if (dly_q == DLY_W'(1)) frame_go = 1'b1;
          else                    dly_d    = dly_q - 1'b1;
        end
        ST_SYNC: begin
          if (bit_q == '0) begin
            word_go    = 1'b1;
            first_word = 1'b1;
          end else begin
            shift = 1'b1;
            bit_d = bit_q - 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_q == '0) begin
            if (word_q == '0) begin
              st_d = ST_IDLE;
              on_d = 1'b0;
            end else begin
              word_go = 1'b1;
              word_d  = word_q - 1'b1;
            end
          end else begin
            shift = 1'b1;
            bit_d = bit_q - 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end

    if (frame_go) begin
      if (cfg_sync_en) begin
        st_d    = ST_SYNC;
        ld_sync = 1'b1;
        bit_d   = sync_len_m1;
        on_d    = 1'b1;
      end else begin
        word_go    = 1'b1;
        first_word = 1'b1;
      end
    end

    if (word_go) begin
      st_d    = ST_DATA;
      bit_d   = word_len_m1;
      on_d    = s_valid;
      ld_word = s_valid;
      if (first_word) word_d = word_cnt_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dly_q  <= '0;
      bit_q  <= '0;
      word_q <= '0;
      on_q   <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      dly_q  <= dly_d;
      bit_q  <= bit_d;
      word_q <= word_d;
      on_q   <= on_d;
      und_q  <= word_go && !s_valid;
    end
  end

  assign s_ready  = word_go;
  assign line_on  = on_q;
  assign busy     = (st_q != ST_IDLE);
  assign underrun = und_q;
endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx #(
  parameter int NSRC   = 4,
  parameter int WORD_W = 16,
  parameter int SYNC_W = 16,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 4,
  localparam int SSW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int WLW   = $clog2(WORD_W),
  localparam int SLW   = $clog2(SYNC_W),
  localparam int SHW   = (WORD_W > SYNC_W) ? WORD_W : SYNC_W,
  localparam int LW    = $clog2(SHW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [NSRC-1:0]   start_evt,
  input  logic [SSW-1:0]    cfg_start_sel,
  input  logic [DLY_W-1:0]  cfg_dly,
  input  logic              cfg_sync_en,
  input  logic [SLW-1:0]    cfg_sync_len_m1,
  input  logic [SYNC_W-1:0] cfg_sync_data,
  input  logic [WLW-1:0]    cfg_word_len_m1,
  input  logic [CNT_W-1:0]  cfg_word_cnt_m1,
  input  logic              cfg_msb_first,
  input  logic              cfg_idle_lvl,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              tx_data,
  output logic              tx_busy,
  output logic              underrun
);
  logic           start_hit;
  logic           ld_sync, ld_word, shift, line_on;
  logic           sh_bit;
  logic [LW-1:0]  sync_len, word_len;
  logic [SHW-1:0] load_val;
  logic [LW-1:0]  load_len;

  assign sync_len = LW'(cfg_sync_len_m1);
  assign word_len = LW'(cfg_word_len_m1);
  assign load_val = ld_sync ? SHW'(cfg_sync_data) : SHW'(s_data);
  assign load_len = ld_sync ? sync_len : word_len;

  ssx_start_pick #(.NSRC(NSRC)) u_pick (
    .start_evt (start_evt),
    .sel       (cfg_start_sel),
    .hit       (start_hit)
  );

  ssx_sequencer #(.DLY_W(DLY_W), .CNT_W(CNT_W), .LW(LW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .start_hit   (start_hit),
    .cfg_dly     (cfg_dly),
    .cfg_sync_en (cfg_sync_en),
    .sync_len_m1 (sync_len),
    .word_len_m1 (word_len),
    .word_cnt_m1 (cfg_word_cnt_m1),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .ld_sync     (ld_sync),
    .ld_word     (ld_word),
    .shift       (shift),
    .line_on     (line_on),
    .busy        (tx_busy),
    .underrun    (underrun)
  );

  ssx_shifter #(.SHW(SHW)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ld_sync || ld_word),
    .shift       (shift),
    .load_val    (load_val),
    .load_len_m1 (load_len),
    .msb_first   (cfg_msb_first),
    .bit_o       (sh_bit)
  );

  assign tx_data = line_on ? sh_bit : cfg_idle_lvl;
endmodule

// File: rtl/frame_serial_tx_chk.sv
module frame_serial_tx_chk #(
  parameter int NSRC = 4,
  localparam int SSW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bit_en,
  input logic [NSRC-1:0] start_evt,
  input logic [SSW-1:0]  cfg_start_sel,
  input logic            cfg_idle_lvl,
  input logic            s_valid,
  input logic            s_ready,
  input logic            tx_data,
  input logic            tx_busy,
  input logic            underrun
);
  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_data == cfg_idle_lvl);

  // R2
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(bit_en && start_evt[cfg_start_sel]));

  // R8
  ready_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_en);

  // R8
  taken_word_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> tx_busy);

  // R9
  underrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> underrun);

  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(s_ready && !s_valid));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_busy));
endmodule

bind frame_serial_tx frame_serial_tx_chk #(.NSRC(NSRC)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_en        (bit_en),
  .start_evt     (start_evt),
  .cfg_start_sel (cfg_start_sel),
  .cfg_idle_lvl  (cfg_idle_lvl),
  .s_valid       (s_valid),
  .s_ready       (s_ready),
  .tx_data       (tx_data),
  .tx_busy       (tx_busy),
  .underrun      (underrun)
);

// File: tb/test_frame_serial_tx.sv
module test_frame_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic [3:0]  start_evt = '0;
  logic [1:0]  cfg_start_sel = '0;
  logic [7:0]  cfg_dly = '0;
  logic        cfg_sync_en = 1'b0;
  logic [3:0]  cfg_sync_len_m1 = '0;
  logic [15:0] cfg_sync_data = '0;
  logic [3:0]  cfg_word_len_m1 = '0;
  logic [3:0]  cfg_word_cnt_m1 = '0;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_idle_lvl = 1'b1;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        s_ready, tx_data, tx_busy, underrun;

  int n_chk = 0;
  int n_fail = 0;
  logic        exp_q[$];
  logic [15:0] wdata[16];
  logic        avail[16];
  int slot, n_take, n_rdy_und, n_und_seen;

  always #10 clk = ~clk;

  frame_serial_tx i_frame_serial_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start_evt(start_evt),
    .cfg_start_sel(cfg_start_sel), .cfg_dly(cfg_dly), .cfg_sync_en(cfg_sync_en),
    .cfg_sync_len_m1(cfg_sync_len_m1), .cfg_sync_data(cfg_sync_data),
    .cfg_word_len_m1(cfg_word_len_m1), .cfg_word_cnt_m1(cfg_word_cnt_m1),
    .cfg_msb_first(cfg_msb_first), .cfg_idle_lvl(cfg_idle_lvl),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tx_data(tx_data), .tx_busy(tx_busy), .underrun(underrun)
  );

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic pick(input logic [15:0] w, input int len, input int b, input logic msb);
    return msb ? w[len-1-b] : w[b];
  endfunction

  task automatic step(input logic [3:0] evt);
    logic t0, b0;
    @(negedge clk);
    bit_en    = 1'b1;
    start_evt = evt;
    s_valid   = (slot < 16) ? avail[slot] : 1'b0;
    s_data    = (slot < 16) ? wdata[slot] : 16'h0;
    #1;
    if (s_ready) begin
      if (s_valid) n_take++;
      else         n_rdy_und++;
      slot++;
    end
    @(posedge clk);
    #1;
    bit_en    = 1'b0;
    start_evt = '0;
    s_valid   = 1'b0;
    if (underrun) n_und_seen++;
    t0 = tx_data;
    b0 = tx_busy;
    repeat ($urandom_range(0, 2)) @(posedge clk);
    #1;
    // R12: nothing moves without an enable
    chk(tx_data == t0 && tx_busy == b0, "R12", int'(tx_data), int'(t0));
  endtask

  task automatic run_frame(input int sel, input int dly, input logic sen, input int slen,
                           input logic [15:0] sval, input int wlen, input int wcnt,
                           input logic msb, input logic idle, input logic spur);
    int flen, und_exp, dstart;
    logic [3:0] evt;
    string tag;
    @(negedge clk);
    cfg_start_sel   = 2'(sel);
    cfg_dly         = 8'(dly);
    cfg_sync_en     = sen;
    cfg_sync_len_m1 = 4'(slen - 1);
    cfg_sync_data   = sval;
    cfg_word_len_m1 = 4'(wlen - 1);
    cfg_word_cnt_m1 = 4'(wcnt - 1);
    cfg_msb_first   = msb;
    cfg_idle_lvl    = idle;
    exp_q.delete();
    und_exp = 0;
    for (int i = 0; i < dly; i++) exp_q.push_back(idle);
    if (sen) for (int b = 0; b < slen; b++) exp_q.push_back(pick(sval, slen, b, msb));
    dstart = exp_q.size();
    for (int s = 0; s < wcnt; s++) begin
      if (!avail[s]) und_exp++;
      for (int b = 0; b < wlen; b++)
        exp_q.push_back(avail[s] ? pick(wdata[s], wlen, b, msb) : idle);
    end
    flen = exp_q.size();
    for (int i = 0; i < 4; i++) exp_q.push_back(idle);
    slot = 0; n_take = 0; n_rdy_und = 0; n_und_seen = 0;
    for (int k = 0; k < exp_q.size(); k++) begin
      if (k == 0)         evt = 4'(1 << sel);
      else if (k <= flen) evt = spur ? 4'hF : 4'h0;  // R10: starts mid-frame
      else                evt = ~4'(1 << sel);       // R2: unselected sources only
      step(evt);
      if (k < dly)         tag = "R3";
      else if (k < dstart) tag = "R4";
      else if (k < flen)   tag = "R7";
      else                 tag = "R2";
      chk(tx_data == exp_q[k], tag, int'(tx_data), int'(exp_q[k]));
      // R11 busy window, R10 no restart after the frame
      chk(tx_busy == (k < flen), "R11", int'(tx_busy), int'(k < flen));
    end
    // R6 slot count, R5 words consumed, R9 underrun pulses, R8 handshake count
    chk(n_take == wcnt - und_exp, "R6", n_take, wcnt - und_exp);
    chk(n_und_seen == und_exp, "R9", n_und_seen, und_exp);
    chk(n_rdy_und == und_exp, "R8", n_rdy_und, und_exp);
  endtask

  task automatic fill_words(input int miss_pct);
    for (int i = 0; i < 16; i++) begin
      wdata[i] = 16'($urandom);
      avail[i] = ($urandom_range(0, 99) >= miss_pct);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    fill_words(0);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(tx_data == 1'b1, "R1", int'(tx_data), 1);
    chk(tx_busy == 1'b0 && s_ready == 1'b0 && underrun == 1'b0, "R1", int'(tx_busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle level follows configuration
    cfg_idle_lvl = 1'b0;
    #1;
    chk(tx_data == 1'b0, "R1", int'(tx_data), 0);

    // R3 zero delay, single MSB-first byte
    wdata[0] = 16'h00A5;
    run_frame(0, 0, 1'b0, 1, 16'h0, 8, 1, 1'b1, 1'b0, 1'b0);
    // R4 sync with delay, R7 LSB first
    fill_words(0);
    run_frame(2, 3, 1'b1, 4, 16'h0009, 5, 3, 1'b0, 1'b1, 1'b0);
    // R9 underrun in the first slot and a middle slot, R10 spurious starts
    fill_words(0);
    avail[0] = 1'b0;
    avail[2] = 1'b0;
    run_frame(1, 0, 1'b1, 1, 16'h0001, 3, 4, 1'b1, 1'b0, 1'b1);
    // R5 full width, R4 full sync, R6 max count
    fill_words(0);
    run_frame(3, 1, 1'b1, 16, 16'hC3A1, 16, 16, 1'b1, 1'b1, 1'b1);
    // R5 one-bit words
    fill_words(20);
    run_frame(0, 2, 1'b0, 1, 16'h0, 1, 7, 1'b0, 1'b0, 1'b1);
    // R3 largest delay
    fill_words(0);
    run_frame(2, 255, 1'b0, 1, 16'h0, 4, 2, 1'b1, 1'b1, 1'b1);

    for (int r = 0; r < 25; r++) begin
      fill_words(15);
      run_frame($urandom_range(0, 3), $urandom_range(0, 5), 1'($urandom),
                $urandom_range(1, 16), 16'($urandom), $urandom_range(1, 16),
                $urandom_range(1, 6), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule